// File: doc/BRIEF.md
# Conditional Branch and Loop Evaluator

This block decides whether a conditional jump, a counted loop step or a count-register-zero jump is taken. Each request arrives as a single-cycle strobe. With it come the instruction kind, a 4-bit condition selector, the five status flags (carry, zero, sign, overflow, parity), the 16-bit count register, the address of the next instruction and an 8-bit signed displacement. The evaluator works out the taken decision, the count value to write back and the short-branch target address. It presents all three on registered outputs exactly one clock after the strobe.

Condition codes come in pairs. The upper three selector bits choose a base test and the lowest bit inverts it, so a decoder can map every synonym mnemonic onto one of sixteen codes. The loop kinds decrement the count first and then test the new value. Two of them also apply an early exit that depends on the zero flag. The target adder always runs and leaves the segment untouched, so the fetch unit can use the address whenever `taken` is high.

Top module: `brcond_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `taken`, `cx_out` and `target_ip` become zero.
- R2: `out_valid` is high in the single cycle that follows each cycle with `in_valid` high, and low otherwise. `taken`, `cx_out` and `target_ip` update one clock after a strobe and keep their values while `in_valid` is low.
- R3: With `in_kind`=0 (conditional), the single-flag selectors are: 0 = OF set, 2 = CF set, 4 = ZF set, 8 = SF set, 10 = PF set. Each odd code 1, 3, 5, 9, 11 is taken exactly when its even partner is not.
- R4: Selector 6 (unsigned below-or-equal) is taken when CF or ZF is 1. Selector 7 is taken only when both CF and ZF are 0.
- R5: Selector 12 (signed less) is taken when SF differs from OF, and selector 13 when they match. Selector 14 is taken when ZF is 1 or SF differs from OF. Selector 15 (signed greater) is taken when ZF is 0 and SF equals OF.
- R6: With `in_kind`=1 (plain loop), `cx_out` = `cx_in` - 1 modulo 2^16, and `taken` is 1 exactly when that new value is non-zero. A start value of 0 wraps to 0xFFFF and is taken.
- R7: With `in_kind`=2 (loop while zero), the count decrements as in R6, and `taken` is 1 only when the new count is non-zero and ZF is 1.
- R8: With `in_kind`=3 (loop while not zero), the count decrements as in R6, and `taken` is 1 only when the new count is non-zero and ZF is 0.
- R9: With `in_kind`=4 (jump on count zero), `taken` is 1 exactly when `cx_in` is 0, and `cx_out` equals `cx_in`.
- R10: With `in_kind`=0, `cx_out` equals `cx_in`. Kinds 5 to 7 are reserved: they give `taken`=0 and `cx_out`=`cx_in` whatever the flags and selector hold.
- R11: On every strobe, `target_ip` = `ip_next` + sign-extended `disp`, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_kind | input | 3 | 0 cond, 1 loop, 2 loop-while-zero, 3 loop-while-not-zero, 4 jump-on-count-zero |
| cond_sel | input | 4 | Condition selector for kind 0 |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_pf | input | 1 | Parity flag |
| cx_in | input | 16 | Current count register |
| ip_next | input | 16 | Address of the following instruction |
| disp | input | 8 | Signed short displacement |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| taken | output | 1 | Branch or loop decision |
| cx_out | output | 16 | Count value to write back |
| target_ip | output | 16 | Short-branch target address |

## Verification
The result registers load only on a strobe, so a decision or count that is wrong internally appears at `taken` or `cx_out` in the cycle right after that strobe. It then stays visible until the next strobe, which lets a stuck or stale register be caught by strobing with new inputs and by idling with changed inputs. A wrong inversion bit or a swapped base test shows up as a mismatch for one specific selector and flag pattern. For that reason the bench sweeps every selector across all 32 flag combinations. A misplaced decrement, or a test of the old count instead of the new one, shows up only at counts 0, 1 and 2, so those values are driven for each loop kind.

// File: rtl/brcond_pkg.sv
package brcond_pkg;
  localparam logic [2:0] KIND_COND    = 3'd0;
  localparam logic [2:0] KIND_LOOP    = 3'd1;
  localparam logic [2:0] KIND_LOOP_Z  = 3'd2;
  localparam logic [2:0] KIND_LOOP_NZ = 3'd3;
  localparam logic [2:0] KIND_JCZ     = 3'd4;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic pf;
  } flags_t;
endpackage

// File: rtl/brcond_flag_eval.sv
module brcond_flag_eval
  import brcond_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  flags_t           fl,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  localparam int NBASE = 2 ** (SEL_W - 1);

  logic [NBASE-1:0] base;

  // Base tests indexed by sel[SEL_W-1:1]; extra entries beyond eight are never true.
  always_comb begin
    base    = '0;
    base[0] = fl.of;
    base[1] = fl.cf;
    base[2] = fl.zf;
    base[3] = fl.cf | fl.zf;
    base[4] = fl.sf;
    base[5] = fl.pf;
    base[6] = fl.sf ^ fl.of;
    base[7] = fl.zf | (fl.sf ^ fl.of);
  end

  // Low selector bit picks the complementary sense of the pair.
  assign hit = base[sel[SEL_W-1:1]] ^ sel[0];
endmodule

// File: rtl/brcond_loop_eval.sv
module brcond_loop_eval
  import brcond_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [2:0]       kind,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             zf,
  output logic             taken,
  output logic [CNT_W-1:0] cnt_out
);
  logic [CNT_W-1:0] cnt_dec;
  logic             dec_nz;

  assign cnt_dec = cnt_in - CNT_W'(1);
  assign dec_nz  = |cnt_dec;

  always_comb begin
    taken   = 1'b0;
    cnt_out = cnt_in;
    unique case (kind)
      KIND_LOOP: begin
        cnt_out = cnt_dec;
        taken   = dec_nz;
      end
      KIND_LOOP_Z: begin
        cnt_out = cnt_dec;
        taken   = dec_nz & zf;
      end
      KIND_LOOP_NZ: begin
        cnt_out = cnt_dec;
        taken   = dec_nz & ~zf;
      end
      KIND_JCZ: taken = ~(|cnt_in);
      default: ;
    endcase
  end
endmodule

// File: rtl/brcond_target_add.sv
module brcond_target_add #(
  parameter int IP_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic [IP_W-1:0]   ip_next,
  input  logic [DISP_W-1:0] disp,
  output logic [IP_W-1:0]   target
);
  logic [IP_W-1:0] disp_ext;

  generate
    if (DISP_W < IP_W) begin : g_sext
      assign disp_ext = {{(IP_W - DISP_W){disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[IP_W-1:0];
    end
  endgenerate

  assign target = ip_next + disp_ext;
endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
  import brcond_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int CX_W   = 16,
  parameter int IP_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_kind,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic              flag_cf,
  input  logic              flag_zf,
  input  logic              flag_sf,
  input  logic              flag_of,
  input  logic              flag_pf,
  input  logic [CX_W-1:0]   cx_in,
  input  logic [IP_W-1:0]   ip_next,
  input  logic [DISP_W-1:0] disp,
  output logic              out_valid,
  output logic              taken,
  output logic [CX_W-1:0]   cx_out,
  output logic [IP_W-1:0]   target_ip
);
  flags_t          fl;
  logic            cond_hit;
  logic            loop_taken;
  logic [CX_W-1:0] loop_cnt;
  logic [IP_W-1:0] tgt_c;
  logic            taken_c;

  assign fl = '{cf: flag_cf, zf: flag_zf, sf: flag_sf, of: flag_of, pf: flag_pf};

  brcond_flag_eval #(.SEL_W(SEL_W)) u_flag (
    .fl  (fl),
    .sel (cond_sel),
    .hit (cond_hit)
  );

  brcond_loop_eval #(.CNT_W(CX_W)) u_loop (
    .kind    (in_kind),
    .cnt_in  (cx_in),
    .zf      (flag_zf),
    .taken   (loop_taken),
    .cnt_out (loop_cnt)
  );

  brcond_target_add #(.IP_W(IP_W), .DISP_W(DISP_W)) u_tgt (
    .ip_next (ip_next),
    .disp    (disp),
    .target  (tgt_c)
  );

  assign taken_c = (in_kind == KIND_COND) ? cond_hit : loop_taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      cx_out    <= '0;
      target_ip <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken     <= taken_c;
        cx_out    <= loop_cnt;
        target_ip <= tgt_c;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_LOOP_DECREMENTS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_kind == KIND_LOOP || in_kind == KIND_LOOP_Z || in_kind == KIND_LOOP_NZ))
    |=> (cx_out == CX_W'($past(cx_in) - CX_W'(1)))); // R6
  AST_LOOP_LAST_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_kind == KIND_LOOP || in_kind == KIND_LOOP_Z || in_kind == KIND_LOOP_NZ)
     && cx_in == CX_W'(1)) |=> !taken); // R7
  AST_JCZ_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == KIND_JCZ) |=> (cx_out == $past(cx_in))); // R9
  AST_RESERVED_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind > KIND_JCZ) |=> (!taken && cx_out == $past(cx_in))); // R10
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> ($stable(cx_out) && $stable(target_ip) && $stable(taken))); // R2
endmodule

// File: tb/tb_brcond_unit.sv
`timescale 1ns/1ps
module tb_brcond_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  in_kind;
  logic [3:0]  cond_sel;
  logic        flag_cf, flag_zf, flag_sf, flag_of, flag_pf;
  logic [15:0] cx_in, ip_next;
  logic [7:0]  disp;
  logic        out_valid, taken;
  logic [15:0] cx_out, target_ip;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brcond_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .cond_sel(cond_sel),
    .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of),
    .flag_pf(flag_pf), .cx_in(cx_in), .ip_next(ip_next), .disp(disp),
    .out_valid(out_valid), .taken(taken), .cx_out(cx_out), .target_ip(target_ip)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flags packed as {cf,zf,sf,of,pf}
  function automatic bit cond_model(input int sel, input logic [4:0] f);
    bit cf = f[4], zf = f[3], sf = f[2], of = f[1], pf = f[0];
    bit r;
    case (sel / 2)
      0: r = of;
      1: r = cf;
      2: r = zf;
      3: r = cf | zf;
      4: r = sf;
      5: r = pf;
      6: r = sf != of;
      default: r = zf | (sf != of);
    endcase
    return r ^ sel[0];
  endfunction

  task automatic apply(input logic [2:0] k, input logic [3:0] s, input logic [4:0] f,
                       input logic [15:0] c, input logic [15:0] ip, input logic [7:0] d);
    @(negedge clk);
    in_kind = k; cond_sel = s;
    {flag_cf, flag_zf, flag_sf, flag_of, flag_pf} = f;
    cx_in = c; ip_next = ip; disp = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; in_kind = 3'd0; cond_sel = 4'd0;
    {flag_cf, flag_zf, flag_sf, flag_of, flag_pf} = 5'd0;
    cx_in = 16'h1234; ip_next = 16'h5678; disp = 8'h10;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "taken", taken, 0);
    chk("R1", "cx_out", cx_out, 0);
    chk("R1", "target_ip", target_ip, 0);
  endtask

  task automatic t_cond_range(input string req, input int sel);
    for (int f = 0; f < 32; f++) begin
      apply(3'd0, 4'(sel), 5'(f), 16'h00A5 + 16'(f), 16'h1000, 8'h04);
      chk(req, $sformatf("taken sel=%0d flags=%0h", sel, f), taken, cond_model(sel, 5'(f)));
      chk("R10", "cond cx_out", cx_out, 16'h00A5 + 16'(f));
    end
  endtask

  task automatic t_single_flag();
    int sels[10] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11};
    foreach (sels[i]) t_cond_range("R3", sels[i]);
  endtask

  task automatic t_unsigned();
    t_cond_range("R4", 6);
    t_cond_range("R4", 7);
  endtask

  task automatic t_signed();
    for (int s = 12; s < 16; s++) t_cond_range("R5", s);
  endtask

  task automatic t_loops();
    logic [15:0] vals[4] = '{16'd0, 16'd1, 16'd2, 16'd300};
    foreach (vals[i]) begin
      logic [15:0] nv = vals[i] - 16'd1;
      for (int z = 0; z < 2; z++) begin
        apply(3'd1, 4'd0, {1'b0, 1'(z), 3'b000}, vals[i], 16'h0, 8'h0);
        chk("R6", "loop cx", cx_out, nv);
        chk("R6", "loop taken", taken, nv != 0);
        apply(3'd2, 4'd0, {1'b0, 1'(z), 3'b000}, vals[i], 16'h0, 8'h0);
        chk("R7", "loopz cx", cx_out, nv);
        chk("R7", "loopz taken", taken, (nv != 0) && (z == 1));
        apply(3'd3, 4'd0, {1'b0, 1'(z), 3'b000}, vals[i], 16'h0, 8'h0);
        chk("R8", "loopnz cx", cx_out, nv);
        chk("R8", "loopnz taken", taken, (nv != 0) && (z == 0));
      end
    end
  endtask

  task automatic t_jcz();
    apply(3'd4, 4'd0, 5'h1F, 16'd0, 16'h0, 8'h0);
    chk("R9", "jcz zero taken", taken, 1);
    chk("R9", "jcz zero cx", cx_out, 0);
    apply(3'd4, 4'd0, 5'h00, 16'd1, 16'h0, 8'h0);
    chk("R9", "jcz one taken", taken, 0);
    chk("R9", "jcz one cx", cx_out, 1);
    apply(3'd4, 4'd0, 5'h08, 16'hFFFF, 16'h0, 8'h0);
    chk("R9", "jcz ffff taken", taken, 0);
    chk("R9", "jcz ffff cx", cx_out, 16'hFFFF);
  endtask

  task automatic t_reserved();
    for (int k = 5; k < 8; k++) begin
      apply(3'(k), 4'd4, 5'h1F, 16'd1, 16'h0, 8'h0);
      chk("R10", "reserved taken", taken, 0);
      chk("R10", "reserved cx", cx_out, 1);
      apply(3'(k), 4'd5, 5'h00, 16'd0, 16'h0, 8'h0);
      chk("R10", "reserved taken cx0", taken, 0);
      chk("R10", "reserved cx0", cx_out, 0);
    end
  endtask

  task automatic t_target();
    logic [15:0] ips[4] = '{16'h1000, 16'hFFF0, 16'h0005, 16'h7FFF};
    logic [7:0]  ds[4]  = '{8'h7F, 8'h20, 8'h80, 8'hFF};
    foreach (ips[i]) begin
      logic [15:0] e = ips[i] + {{8{ds[i][7]}}, ds[i]};
      apply(3'd0, 4'd4, 5'h08, 16'h0, ips[i], ds[i]);
      chk("R11", "target", target_ip, e);
    end
  endtask

  task automatic t_timing_hold();
    apply(3'd1, 4'd0, 5'h00, 16'd10, 16'h2000, 8'h10);
    chk("R2", "out_valid after strobe", out_valid, 1);
    chk("R2", "cx after strobe", cx_out, 9);
    in_kind = 3'd4; cx_in = 16'd0; ip_next = 16'h3333; disp = 8'h01;
    @(negedge clk);
    chk("R2", "out_valid idle", out_valid, 0);
    chk("R2", "cx held", cx_out, 9);
    chk("R2", "taken held", taken, 1);
    chk("R2", "target held", target_ip, 16'h2010);
    @(negedge clk);
    chk("R2", "cx still held", cx_out, 9);
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "second strobe valid", out_valid, 1);
    chk("R9", "second strobe taken", taken, 1);
    @(negedge clk);
    chk("R2", "valid is single pulse", out_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_timing_hold();
    t_single_flag();
    t_unsigned();
    t_signed();
    t_loops();
    t_jcz();
    t_reserved();
    t_target();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule